// File: doc/BRIEF.md
# SIMD Lane Shuffle Network

This block reorders the elements of a wide SIMD vector between lanes. It takes a vector of 32 lanes, each holding a 16-bit element, and in one clock cycle moves every element to a new lane position according to one of four fixed patterns: pass-through, perfect shuffle, inverse perfect shuffle, or pairwise exchange of neighbouring lanes. The result is held in an output register and flagged valid for one cycle.

The input of the permutation comes either from the vector presented at the ports or from the block's own output register. Selecting the output register as the source lets a sequence of patterns run one after another, one pattern per cycle. In this way the small set of fixed patterns composes into longer static reorderings, such as the lane orderings between the stages of an FFT butterfly, without the area of a full crossbar.

Top module: `lane_shuffle_net`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `out_valid` is 0 and `out_vec` is all zeros.
- R2: Pattern code 2'b00 passes each lane through unchanged: output lane i equals source lane i.
- R3: Pattern code 2'b01 is the perfect shuffle: output lane i equals source lane j, where j is the 5-bit index i rotated left by one bit (j = {i[3:0], i[4]}).
- R4: Pattern code 2'b10 is the inverse perfect shuffle: output lane i equals source lane j, where j is i rotated right by one bit (j = {i[0], i[4:1]}).
- R5: Pattern code 2'b11 exchanges neighbours: output lane i equals source lane i XOR 1.
- R6: `out_valid` is 1 in the cycle after a clock edge at which `in_valid` was 1, and 0 in the cycle after an edge at which `in_valid` was 0; the result appears with exactly one cycle of latency.
- R7: When `in_valid` is 0 at a clock edge, `out_vec` keeps its value and `pat_sel`, `src_fb` and `in_vec` have no effect on it.
- R8: When `src_fb` is 1 the source vector is the current `out_vec` register, and `in_vec` is ignored; when `src_fb` is 0 the source is `in_vec`. Lane i occupies bits [16*i+15:16*i] of both vectors.
- R9: Chained passes through the feedback path compose: five perfect shuffles in a row, a shuffle followed by an inverse shuffle, and two exchanges in a row each return the originally loaded vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Apply the selected pattern at this edge |
| src_fb | input | 1 | Source select: 0 = `in_vec`, 1 = output register |
| pat_sel | input | 2 | Pattern code: 00 pass, 01 shuffle, 10 inverse shuffle, 11 exchange |
| in_vec | input | 512 | Freshly loaded vector, 32 lanes of 16 bits |
| out_valid | output | 1 | Output register holds a result produced at the previous edge |
| out_vec | output | 512 | Registered permuted vector |

## Verification
The bench targets the lane index arithmetic at its ends: lanes 0, 15, 16 and 31 are where a rotation written as a shift would lose the wrapped bit and send lane 16 or 31 to the wrong place, which the chained five-shuffle return to the original order exposes at once. It also drives feedback passes with unrelated data on `in_vec`, so a source mux that leaks the input shows up as foreign values. Idle cycles with changing pattern and data catch an output register that loads without `in_valid`, and a valid flag that lags or lingers by a cycle is caught by a behavioural model compared on every clock over a long mixed sequence.

// File: rtl/lane_shuf_pkg.sv
package lane_shuf_pkg;

    localparam int DEF_LANES  = 32;
    localparam int DEF_LANE_W = 16;

    typedef enum logic [1:0] {
        PAT_PASS   = 2'b00,
        PAT_SHUF   = 2'b01,
        PAT_UNSHUF = 2'b10,
        PAT_SWAP   = 2'b11
    } pattern_e;

    typedef enum logic {
        SRC_LOAD     = 1'b0,
        SRC_FEEDBACK = 1'b1
    } source_e;

    typedef struct packed {
        logic     fire;
        pattern_e pat;
        source_e  src;
    } shuf_ctrl_t;

    function automatic shuf_ctrl_t make_ctrl(logic v, logic fb, logic [1:0] code);
        shuf_ctrl_t c;
        c.fire = v;
        c.pat  = pattern_e'(code);
        c.src  = fb ? SRC_FEEDBACK : SRC_LOAD;
        return c;
    endfunction

endpackage

// File: rtl/lane_src_mux.sv
module lane_src_mux
    import lane_shuf_pkg::*;
#(
    parameter int VEC_W = DEF_LANES * DEF_LANE_W
) (
    input  source_e          src,
    input  logic [VEC_W-1:0] load_vec,
    input  logic [VEC_W-1:0] fb_vec,
    output logic [VEC_W-1:0] sel_vec
);
    always_comb begin
        unique case (src)
            SRC_FEEDBACK: sel_vec = fb_vec;
            default:      sel_vec = load_vec;
        endcase
    end
endmodule

// File: rtl/lane_perm_stage.sv
module lane_perm_stage
    import lane_shuf_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  pattern_e                pat,
    input  logic [LANES*LANE_W-1:0] src_vec,
    output logic [LANES*LANE_W-1:0] perm_vec
);
    localparam int IDX_W = $clog2(LANES);
    localparam int TOP   = IDX_W - 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // source lane for each pattern, fixed at elaboration
        localparam int I_SHUF   = ((g << 1) | (g >> TOP)) & (LANES - 1);
        localparam int I_UNSHUF = (g >> 1) | ((g & 1) << TOP);
        localparam int I_SWAP   = g ^ 1;

        always_comb begin
            unique case (pat)
                PAT_SHUF:   perm_vec[g*LANE_W +: LANE_W] = src_vec[I_SHUF*LANE_W   +: LANE_W];
                PAT_UNSHUF: perm_vec[g*LANE_W +: LANE_W] = src_vec[I_UNSHUF*LANE_W +: LANE_W];
                PAT_SWAP:   perm_vec[g*LANE_W +: LANE_W] = src_vec[I_SWAP*LANE_W   +: LANE_W];
                default:    perm_vec[g*LANE_W +: LANE_W] = src_vec[g*LANE_W        +: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/lane_out_reg.sv
module lane_out_reg #(
    parameter int VEC_W = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [VEC_W-1:0] d_vec,
    output logic [VEC_W-1:0] q_vec,
    output logic             q_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_vec   <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q_vec <= d_vec;
            end
        end
    end
endmodule

// File: rtl/lane_shuffle_net.sv
module lane_shuffle_net
    import lane_shuf_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    src_fb,
    input  logic [1:0]              pat_sel,
    input  logic [LANES*LANE_W-1:0] in_vec,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_vec
);
    localparam int VEC_W = LANES * LANE_W;

    shuf_ctrl_t       ctrl;
    logic [VEC_W-1:0] src_vec;
    logic [VEC_W-1:0] perm_vec;
    logic [VEC_W-1:0] held_vec;

    assign ctrl = make_ctrl(in_valid, src_fb, pat_sel);

    lane_src_mux #(.VEC_W(VEC_W)) u_src (
        .src      (ctrl.src),
        .load_vec (in_vec),
        .fb_vec   (held_vec),
        .sel_vec  (src_vec)
    );

    lane_perm_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_perm (
        .pat      (ctrl.pat),
        .src_vec  (src_vec),
        .perm_vec (perm_vec)
    );

    lane_out_reg #(.VEC_W(VEC_W)) u_oreg (
        .clk     (clk),
        .rst     (rst),
        .load    (ctrl.fire),
        .d_vec   (perm_vec),
        .q_vec   (held_vec),
        .q_valid (out_valid)
    );

    assign out_vec = held_vec;
endmodule

// File: rtl/lane_shuffle_net_chk.sv
module lane_shuffle_net_chk #(
    parameter int LANES  = 32,
    parameter int LANE_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    src_fb,
    input logic [1:0]              pat_sel,
    input logic [LANES*LANE_W-1:0] in_vec,
    input logic                    out_valid,
    input logic [LANES*LANE_W-1:0] out_vec
);
    localparam int HALF = LANES / 2;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_vec == '0));

    p_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_vec));

    p_shuf_lanes_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !src_fb && pat_sel == 2'b01) |=>
        (out_vec[1*LANE_W +: LANE_W]    == $past(in_vec[2*LANE_W +: LANE_W]) &&
         out_vec[HALF*LANE_W +: LANE_W] == $past(in_vec[1*LANE_W +: LANE_W])));

    p_unshuf_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !src_fb && pat_sel == 2'b10) |=>
        (out_vec[2*LANE_W +: LANE_W] == $past(in_vec[1*LANE_W +: LANE_W]) &&
         out_vec[1*LANE_W +: LANE_W] == $past(in_vec[HALF*LANE_W +: LANE_W])));

    p_swap_fb_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_fb && pat_sel == 2'b11) |=>
        (out_vec[0 +: LANE_W]      == $past(out_vec[LANE_W +: LANE_W]) &&
         out_vec[LANE_W +: LANE_W] == $past(out_vec[0 +: LANE_W])));

    p_pass_fb_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_fb && pat_sel == 2'b00) |=> $stable(out_vec));

    p_pass_load_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !src_fb && pat_sel == 2'b00) |=> (out_vec == $past(in_vec)));
endmodule

bind lane_shuffle_net lane_shuffle_net_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_fb    (src_fb),
    .pat_sel   (pat_sel),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/lane_shuffle_net_tb.sv
`timescale 1ns/1ps
module lane_shuffle_net_tb;
    localparam int N   = 32;
    localparam int W   = 16;
    localparam int VW  = N * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          src_fb = 1'b0;
    logic [1:0]    pat_sel = 2'b00;
    logic [VW-1:0] in_vec = '0;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    logic [VW-1:0] exp_vec = '0;
    logic          exp_valid = 1'b0;
    logic [VW-1:0] orig;

    always #2 clk = ~clk;

    lane_shuffle_net u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_fb(src_fb),
        .pat_sel(pat_sel), .in_vec(in_vec), .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
        return v;
    endfunction

    // behavioural reference: lane index arithmetic on integers
    function automatic int src_lane(int code, int i);
        case (code)
            1: return ((i * 2) % N) + (i / (N / 2));
            2: return (i / 2) + (i % 2) * (N / 2);
            3: return (i % 2 == 0) ? i + 1 : i - 1;
            default: return i;
        endcase
    endfunction

    task automatic model_edge(logic v, logic fb, logic [1:0] code, logic [VW-1:0] din);
        logic [VW-1:0] s, n;
        if (rst) begin
            exp_vec = '0; exp_valid = 1'b0;
        end else begin
            exp_valid = v;
            if (v) begin
                s = fb ? exp_vec : din;
                for (int i = 0; i < N; i++) n[i*W +: W] = s[src_lane(int'(code), i)*W +: W];
                exp_vec = n;
            end
        end
    endtask

    task automatic check(string req);
        tests++;
        if (out_valid !== exp_valid || out_vec !== exp_vec) begin
            fails++;
            $display("FAIL %s: valid=%0b vec=%h expected valid=%0b vec=%h",
                     req, out_valid, out_vec, exp_valid, exp_vec);
        end
    endtask

    task automatic check_vec(string req, logic [VW-1:0] want);
        tests++;
        if (out_vec !== want) begin
            fails++;
            $display("FAIL %s: vec=%h expected %h", req, out_vec, want);
        end
    endtask

    task automatic step(logic v, logic fb, logic [1:0] code, logic [VW-1:0] din, string req);
        @(negedge clk);
        in_valid = v; src_fb = fb; pat_sel = code; in_vec = din;
        @(posedge clk);
        model_edge(v, fb, code, din);
        #1;
        check(req);
    endtask

    initial begin
        logic [VW-1:0] d;
        rst = 1'b1;
        repeat (3) begin
            @(posedge clk); model_edge(1'b0, 1'b0, 2'b00, '0); #1; check("R1 reset");
        end
        @(negedge clk); rst = 1'b0; in_vec = rand_vec(); in_valid = 1'b0;
        @(posedge clk); model_edge(1'b0, 1'b0, 2'b00, in_vec); #1; check("R1 after reset");

        step(1, 0, 2'b00, rand_vec(), "R2 pass");
        step(1, 0, 2'b01, rand_vec(), "R3 shuffle");
        step(1, 0, 2'b10, rand_vec(), "R4 inverse shuffle");
        step(1, 0, 2'b11, rand_vec(), "R5 exchange");
        step(0, 0, 2'b01, rand_vec(), "R6 valid drops");
        step(0, 1, 2'b11, rand_vec(), "R7 idle hold");

        // index-as-data: lane i carries i, so wraps at lanes 16/31 are visible
        for (int i = 0; i < N; i++) d[i*W +: W] = W'(i);
        step(1, 0, 2'b01, d, "R3 shuffle index data");
        step(1, 0, 2'b10, d, "R4 inverse index data");

        // five chained shuffles return the original (R9), in_vec noise ignored (R8)
        orig = rand_vec();
        step(1, 0, 2'b00, orig, "R9 load");
        for (int k = 0; k < 5; k++) step(1, 1, 2'b01, rand_vec(), "R8 feedback shuffle");
        check_vec("R9 five shuffles", orig);

        step(1, 1, 2'b01, rand_vec(), "R8 feedback shuffle");
        step(1, 1, 2'b10, rand_vec(), "R8 feedback inverse");
        check_vec("R9 shuffle then inverse", orig);

        step(1, 1, 2'b11, rand_vec(), "R5 feedback exchange");
        step(1, 1, 2'b11, rand_vec(), "R5 feedback exchange");
        check_vec("R9 two exchanges", orig);

        step(1, 1, 2'b00, rand_vec(), "R8 feedback pass");
        check_vec("R8 feedback pass keeps", orig);

        for (int k = 0; k < 400; k++)
            step(1'($urandom), 1'($urandom), 2'($urandom), rand_vec(), "R6 mixed run");

        // mid-run reset
        @(negedge clk); rst = 1'b1; in_valid = 1'b1;
        @(posedge clk); model_edge(1'b1, 1'b0, 2'b00, in_vec); #1; check("R1 mid reset");
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule